// File: doc/BRIEF.md
# Character LCD Host Bus Interface

This block sits between a microprocessor and the rest of a character LCD controller. The host drives an enable strobe together with a register-select line, a read/write line and a data byte. The block synchronises the enable strobe into its own clock domain and acts on each falling edge. It turns the select and direction lines into one of four transfers: instruction write, status read, data write and data read.

Inside, the block keeps an instruction register, a data register and a 7-bit address counter, and it talks to an external display/character RAM through a single port with a registered read. A data write goes straight on to the RAM at the counter's address. A data read hands the host the data register and then refills it from the next address. While an internal operation runs, a busy flag is raised and the block refuses writes. The host can still poll the flag through a status read, which also shows the live address counter. The host bus can be 8 bits wide, or 4 bits wide, in which case each byte moves as two nibbles on the upper data lines.

Only three instruction kinds are decoded here: bus width, address set and entry direction. Every accepted instruction byte is also passed on through a strobed instruction output, so that the rest of the controller can decode it.

Top module: `lcd_host_if`

## Requirements
- R1: The transfer kind is chosen by {hst_rs, hst_rw}: 00 is an instruction write, 01 a status read, 10 a data write and 11 a data read.
- R2: A status read drives the busy flag on bit 7 and the address counter on bits 6..0 of hst_dout.
- R3: The instruction register never shows up on hst_dout. Each accepted instruction byte appears on ir_code, together with a one-cycle pulse on ir_stb.
- R4: An instruction whose bits 7..5 are 001 sets the bus width from bit 4 (1 = 8-bit, 0 = 4-bit) and clears the nibble toggle.
- R5: In 4-bit mode only hst_din[7:4] is used, carrying the high nibble on the first strobe and the low nibble on the second. Reads return the matching nibble on hst_dout[7:4], with hst_dout[3:0] held at zero.
- R6: An instruction with bit 7 set loads bits 6..0 into the address counter and reloads the data register from RAM at that address.
- R7: An instruction whose bits 7..2 are 000001 sets the step direction from bit 1 (1 = increment, 0 = decrement). The counter wraps modulo 128.
- R8: A data write puts the byte at the counter's RAM address with a one-cycle ram_we pulse, then steps the counter.
- R9: A data read returns the data register, then steps the counter and reloads the data register from RAM at the new address.
- R10: The busy flag is high for BUSY_CYC cycles after each accepted instruction or data write, and while a data register reload is pending. Instruction and data writes that arrive while it is high are ignored. Reads are always served.
- R11: After reset the address counter is 0, the data register is 0, busy is low, the bus is 8 bits wide and the step direction is increment.
- R12: A transfer takes effect only on the falling edge of hst_en. Holding hst_en high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_en | input | 1 | Host enable strobe (asynchronous; acts on falling edge) |
| hst_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| hst_rw | input | 1 | Direction: 1 read, 0 write |
| hst_din | input | 8 | Host write data (upper nibble only in 4-bit mode) |
| hst_dout | output | 8 | Host read data, registered |
| ram_addr | output | ADDR_W | RAM address |
| ram_we | output | 1 | RAM write enable, one-cycle pulse |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after the address |
| ir_code | output | 8 | Last accepted instruction byte |
| ir_stb | output | 1 | One-cycle pulse when ir_code is updated |

## Verification
The bench goes after wrap of the counter in both directions. A wrong wrap would leave 0x7F or 0x00 unreached, or write outside the 128-byte space. It also checks read prefetch right after an address set and after each data read. A design without the reload, or one that reloads before the counter steps, would return the same byte twice or skip one. In 4-bit mode it drives junk on the low data lines, to catch a design that assembles bytes from them or swaps the nibble order. It issues instruction and data writes inside the busy window, which a design without gating would carry out. Finally, it holds the enable strobe high for a long time, to catch a design that acts on the level or on the rising edge.

// File: rtl/lcd_host_pkg.sv
package lcd_host_pkg;

  localparam int BYTE_W = 8;

  // Transfer kind, encoded as {rs, rw} (R1)
  typedef enum logic [1:0] {
    OP_IWR  = 2'b00,
    OP_STAT = 2'b01,
    OP_DWR  = 2'b10,
    OP_DRD  = 2'b11
  } host_op_e;

  function automatic logic is_addr_set(input logic [BYTE_W-1:0] c);
    return c[7];
  endfunction

  function automatic logic is_width_set(input logic [BYTE_W-1:0] c);
    return c[7:5] == 3'b001;
  endfunction

  function automatic logic is_dir_set(input logic [BYTE_W-1:0] c);
    return c[7:2] == 6'b000001;
  endfunction

endpackage

// File: rtl/lcd_strobe_sync.sv
module lcd_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_async,
  output logic fall
);

  // sh[0] is the first synchroniser flop; sh[STAGES] holds the previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      fall <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-1:0], en_async};
      fall <= sh[STAGES] & ~sh[STAGES-1];   // R12: falling edge only
    end
  end

endmodule

// File: rtl/lcd_nibble_pack.sv
module lcd_nibble_pack
  import lcd_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ev,
  input  logic              rs,
  input  logic              rw,
  input  logic [BYTE_W-1:0] din,
  input  logic              wide,
  input  logic              busy,
  input  logic              clr,
  output logic              byte_ev,
  output logic [BYTE_W-1:0] byte_val,
  output host_op_e          byte_op,
  output logic              tog
);

  localparam int NIB_W = BYTE_W / 2;

  logic [NIB_W-1:0] hi_q;
  logic             accept;

  // R10: writes dropped while busy, reads always taken
  assign accept = ev && (rw || !busy);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q     <= '0;
      tog      <= 1'b0;
      byte_ev  <= 1'b0;
      byte_val <= '0;
      byte_op  <= OP_STAT;
    end else begin
      byte_ev <= 1'b0;
      if (accept) begin
        if (wide) begin
          byte_ev  <= 1'b1;
          byte_val <= din;
          byte_op  <= host_op_e'({rs, rw});
        end else if (!tog) begin
          // R5: first strobe carries the high nibble
          hi_q <= din[BYTE_W-1:NIB_W];
          tog  <= 1'b1;
        end else begin
          byte_ev  <= 1'b1;
          byte_val <= {hi_q, din[BYTE_W-1:NIB_W]};
          byte_op  <= host_op_e'({rs, rw});
          tog      <= 1'b0;
        end
      end
      if (clr) tog <= 1'b0;                  // R4
    end
  end

endmodule

// File: rtl/lcd_addr_ctr.sv
module lcd_addr_ctr #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic          inc,
  output logic [AW-1:0] ac
);

  always_ff @(posedge clk) begin
    if (rst)       ac <= '0;                 // R11
    else if (load) ac <= load_val;           // R6
    else if (step) ac <= inc ? AW'(ac + 1'b1) : AW'(ac - 1'b1);  // R7 modular wrap
  end

endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
  parameter int CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic hold,
  output logic busy
);

  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (start)    cnt <= CW'(CYC);
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != 0) || hold;         // R10

endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if
  import lcd_host_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int BUSY_CYC    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_en,
  input  logic              hst_rs,
  input  logic              hst_rw,
  input  logic [BYTE_W-1:0] hst_din,
  output logic [BYTE_W-1:0] hst_dout,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic [BYTE_W-1:0] ram_wdata,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic [BYTE_W-1:0] ir_code,
  output logic              ir_stb
);

  localparam int NIB_W = BYTE_W / 2;

  logic              ev_fall;
  logic              rs_q, rw_q;
  logic [BYTE_W-1:0] din_q;
  logic              wide_q, inc_q;
  logic [BYTE_W-1:0] dr_q;
  logic [ADDR_W-1:0] ac_q;
  logic              busy;
  logic              fetch_req, fetch_s1, fetch_s2;
  logic              byte_ev, nib_tog;
  logic [BYTE_W-1:0] byte_val;
  host_op_e          byte_op;
  logic              act_iwr, act_dwr, act_drd;
  logic              do_addr, do_width, do_dir;
  logic [BYTE_W-1:0] stat_w, src_w, dout_nx;

  // bus lines are held stable around the strobe; one register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      rs_q  <= 1'b0;
      rw_q  <= 1'b0;
      din_q <= '0;
    end else begin
      rs_q  <= hst_rs;
      rw_q  <= hst_rw;
      din_q <= hst_din;
    end
  end

  lcd_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .en_async(hst_en), .fall(ev_fall)
  );

  lcd_nibble_pack u_pack (
    .clk(clk), .rst(rst), .ev(ev_fall), .rs(rs_q), .rw(rw_q), .din(din_q),
    .wide(wide_q), .busy(busy), .clr(do_width),
    .byte_ev(byte_ev), .byte_val(byte_val), .byte_op(byte_op), .tog(nib_tog)
  );

  // R1 decode of the completed transfer
  assign act_iwr  = byte_ev && (byte_op == OP_IWR);
  assign act_dwr  = byte_ev && (byte_op == OP_DWR);
  assign act_drd  = byte_ev && (byte_op == OP_DRD);
  assign do_addr  = act_iwr && is_addr_set(byte_val);
  assign do_width = act_iwr && is_width_set(byte_val);
  assign do_dir   = act_iwr && is_dir_set(byte_val);

  lcd_addr_ctr #(.AW(ADDR_W)) u_ac (
    .clk(clk), .rst(rst), .load(do_addr), .load_val(byte_val[ADDR_W-1:0]),
    .step(act_dwr || act_drd), .inc(inc_q), .ac(ac_q)
  );

  lcd_busy_timer #(.CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst(rst), .start(act_iwr || act_dwr),
    .hold(fetch_req || fetch_s1 || fetch_s2), .busy(busy)
  );

  // R2: status byte; R5: nibble selection for the narrow bus
  always_comb begin
    stat_w             = '0;
    stat_w[ADDR_W-1:0] = ac_q;
    stat_w[BYTE_W-1]   = busy;
    src_w              = rs_q ? dr_q : stat_w;
    if (wide_q)       dout_nx = src_w;
    else if (nib_tog) dout_nx = {src_w[NIB_W-1:0], {NIB_W{1'b0}}};
    else              dout_nx = {src_w[BYTE_W-1:NIB_W], {NIB_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wide_q    <= 1'b1;
      inc_q     <= 1'b1;
      dr_q      <= '0;
      ram_addr  <= '0;
      ram_we    <= 1'b0;
      ram_wdata <= '0;
      fetch_req <= 1'b0;
      fetch_s1  <= 1'b0;
      fetch_s2  <= 1'b0;
      ir_code   <= '0;
      ir_stb    <= 1'b0;
      hst_dout  <= '0;
    end else begin
      ram_we    <= 1'b0;
      ir_stb    <= 1'b0;
      // R6/R9: reload pipeline, issue address then capture registered read
      fetch_req <= do_addr || act_dwr || act_drd;
      fetch_s1  <= fetch_req;
      fetch_s2  <= fetch_s1;
      if (fetch_req) ram_addr <= ac_q;
      if (fetch_s2)  dr_q     <= ram_rdata;
      if (act_dwr) begin                     // R8
        ram_addr  <= ac_q;
        ram_we    <= 1'b1;
        ram_wdata <= byte_val;
      end
      if (act_iwr) begin                     // R3
        ir_code <= byte_val;
        ir_stb  <= 1'b1;
      end
      if (do_width) wide_q <= byte_val[4];   // R4
      if (do_dir)   inc_q  <= byte_val[1];   // R7
      hst_dout <= dout_nx;
    end
  end

endmodule

// File: rtl/lcd_host_if_chk.sv
module lcd_host_if_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          ev,
  input logic          rw,
  input logic          busy,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic [AW-1:0] ac,
  input logic          inc,
  input logic          wide,
  input logic          tog,
  input logic          ir_stb,
  input logic [7:0]    dout
);

  assert_we_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> !ram_we);

  assert_ac_step_R7: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ac == (inc ? AW'(ram_addr + 1'b1) : AW'(ram_addr - 1'b1))));

  assert_busy_block_R10: assert property (@(posedge clk) disable iff (rst)
    (ev && !rw && busy) |=> ##1 (!ram_we && !ir_stb));

  assert_ir_busy_R10: assert property (@(posedge clk) disable iff (rst)
    ir_stb |-> busy);

  assert_stb_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    ir_stb |=> !ir_stb);

  assert_tog_wide_R4: assert property (@(posedge clk) disable iff (rst)
    wide |-> !tog);

  assert_narrow_low_R5: assert property (@(posedge clk) disable iff (rst)
    (!wide && !$past(wide)) |-> (dout[3:0] == 4'h0));

endmodule

bind lcd_host_if lcd_host_if_chk #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ev(ev_fall), .rw(rw_q), .busy(busy),
  .ram_we(ram_we), .ram_addr(ram_addr), .ac(ac_q), .inc(inc_q),
  .wide(wide_q), .tog(nib_tog), .ir_stb(ir_stb), .dout(hst_dout)
);

// File: tb/lcd_host_if_tb.sv
module lcd_host_if_tb;

  localparam int BUSY = 40;
  localparam int GAP  = 60;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hst_en = 1'b0, hst_rs = 1'b0, hst_rw = 1'b0;
  logic [7:0] hst_din = '0, hst_dout;
  logic [6:0] ram_addr;
  logic       ram_we;
  logic [7:0] ram_wdata, ram_rdata;
  logic [7:0] ir_code;
  logic       ir_stb;

  logic [7:0] mem [128];
  int n_chk = 0, n_fail = 0, we_cnt = 0, stb_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  lcd_host_if #(.ADDR_W(7), .BUSY_CYC(BUSY), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .hst_en(hst_en), .hst_rs(hst_rs), .hst_rw(hst_rw),
    .hst_din(hst_din), .hst_dout(hst_dout), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .ir_code(ir_code), .ir_stb(ir_stb)
  );

  initial for (int i = 0; i < 128; i++) mem[i] = 8'h00;

  always @(posedge clk) begin
    if (ram_we) begin
      mem[ram_addr] <= ram_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (ir_stb) stb_cnt <= stb_cnt + 1;
    ram_rdata <= mem[ram_addr];
  end

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 29 + 7) ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus(input logic rs, input logic rw, input logic [7:0] d,
                     input int gap, output logic [7:0] q);
    @(negedge clk);
    hst_rs = rs; hst_rw = rw; hst_din = d; hst_en = 1'b1;
    repeat (6) @(negedge clk);
    q = hst_dout;
    hst_en = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] q, q2;
    int w0, s0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R11 reset state
    chk("R11 ir_stb idle", {7'b0, ir_stb}, 8'h00);
    bus(0, 1, 8'h00, GAP, q); chk("R11 status after reset", q, 8'h00);
    bus(1, 1, 8'h00, GAP, q); chk("R11 data register after reset", q, 8'h00);
    bus(0, 1, 8'h00, GAP, q); chk("R9 read stepped counter", q, 8'h01);

    // R6 address sweep, R2 status format
    for (int a = 0; a < 128; a++) begin
      bus(0, 0, 8'(8'h80 | a), GAP, q);
      bus(0, 1, 8'h00, GAP, q);
      chk("R6 R2 address set", q, 8'(a));
    end

    // R3 instruction write: visible on ir_code, never on data bus
    s0 = stb_cnt;
    bus(0, 0, 8'h06, GAP, q);
    chk("R3 ir_code", ir_code, 8'h06);
    chk("R3 ir_stb count", 8'(stb_cnt - s0), 8'h01);
    bus(0, 1, 8'h00, GAP, q); chk("R3 status not IR", q, 8'h7F);

    // R8 write sweep with wrap, R1 data write path
    bus(0, 0, 8'h80, GAP, q);
    s0 = stb_cnt;
    for (int i = 0; i < 128; i++) bus(1, 0, pat(i), GAP, q);
    chk("R1 data write raises no ir_stb", 8'(stb_cnt - s0), 8'h00);
    for (int i = 0; i < 128; i++) chk("R8 ram content", mem[i], pat(i));
    bus(0, 1, 8'h00, GAP, q); chk("R7 increment wrap to 0", q, 8'h00);

    // R9 read sweep with prefetch
    bus(0, 0, 8'h80, GAP, q);
    for (int i = 0; i < 128; i++) begin
      bus(1, 1, 8'h00, GAP, q);
      chk("R9 data read", q, pat(i));
    end

    // R7 decrement and wrap below zero
    bus(0, 0, 8'h04, GAP, q);
    bus(0, 0, 8'h81, GAP, q);
    bus(1, 0, 8'hA1, GAP, q);
    bus(1, 0, 8'hA2, GAP, q);
    chk("R7 dec write 1", mem[1], 8'hA1);
    chk("R7 dec write 0", mem[0], 8'hA2);
    bus(0, 1, 8'h00, GAP, q); chk("R7 decrement wrap to 7F", q, 8'h7F);
    bus(0, 0, 8'h81, GAP, q);
    bus(1, 1, 8'h00, GAP, q); chk("R9 dec read 1", q, 8'hA1);
    bus(1, 1, 8'h00, GAP, q); chk("R9 dec read 0", q, 8'hA2);
    bus(0, 1, 8'h00, GAP, q); chk("R7 dec read wrap", q, 8'h7F);
    bus(0, 0, 8'h06, GAP, q);

    // R10 busy: status shows busy, writes during busy ignored
    bus(0, 0, 8'h90, 8, q);
    bus(0, 1, 8'h00, 2, q); chk("R10 R2 busy visible in status", q, 8'h90);
    bus(0, 0, 8'hA0, GAP, q);
    bus(0, 1, 8'h00, GAP, q); chk("R10 instruction ignored while busy", q, 8'h10);
    w0 = we_cnt;
    bus(0, 0, 8'hB0, 8, q);
    bus(1, 0, 8'hEE, GAP, q);
    chk("R10 data write ignored while busy", 8'(we_cnt - w0), 8'h00);
    bus(0, 1, 8'h00, GAP, q); chk("R10 counter unchanged", q, 8'h30);

    // R12 only the falling edge acts
    w0 = we_cnt;
    @(negedge clk);
    hst_rs = 1'b1; hst_rw = 1'b0; hst_din = 8'h77; hst_en = 1'b1;
    repeat (30) @(negedge clk);
    chk("R12 no action while enable high", 8'(we_cnt - w0), 8'h00);
    hst_en = 1'b0;
    repeat (GAP) @(negedge clk);
    chk("R12 action after falling edge", 8'(we_cnt - w0), 8'h01);
    chk("R12 written byte", mem[8'h30], 8'h77);

    // R4 / R5 narrow bus
    bus(0, 0, 8'h20, GAP, q);                       // width set, DL=0
    bus(0, 0, 8'h0F, GAP, q); bus(0, 0, 8'h6F, GAP, q);
    chk("R5 nibble instruction, low lines ignored", ir_code, 8'h06);
    bus(0, 0, 8'h8F, GAP, q); bus(0, 0, 8'h5F, GAP, q);
    bus(0, 1, 8'h00, GAP, q); bus(0, 1, 8'h00, GAP, q2);
    chk("R5 status high nibble", q, 8'h00);
    chk("R5 status low nibble", q2, 8'h50);
    bus(1, 0, 8'h3A, GAP, q); bus(1, 0, 8'hC5, GAP, q);
    chk("R5 nibble data write", mem[5], 8'h3C);
    bus(0, 0, 8'h8F, GAP, q); bus(0, 0, 8'h5F, GAP, q);
    bus(1, 1, 8'h00, GAP, q); bus(1, 1, 8'h00, GAP, q2);
    chk("R5 data read high nibble", q, 8'h30);
    chk("R5 data read low nibble", q2, 8'hC0);
    bus(0, 0, 8'h30, GAP, q); bus(0, 0, 8'h0F, GAP, q);  // back to 8-bit
    bus(0, 1, 8'h00, GAP, q); chk("R4 wide again, status full byte", q, 8'h06);
    bus(1, 1, 8'h00, GAP, q); chk("R4 R9 wide data read", q, mem[6]);

    done = 1;
    summary();
    $finish;
  end

endmodule